// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a simple request port and a 16-bit asynchronous parallel NOR flash bus. It performs three operations on request: reading the identification codes, erasing one sector, and programming one word. For each operation it emits the flash command writes in order. It polls the status bit until the device reports completion or a programmable timeout expires, and it then puts the device back into array-read mode. Two command dialects are supported. The unlock style precedes each command with two unlock writes. The block style writes short opcodes straight to the sector address and clears a status register after each poll.

A request is accepted only while the sequencer is idle, and busy stays high until the one-cycle done pulse. Erasing a range of sectors is done by issuing one erase request per sector. Each request runs to completion before the next one is accepted, so erases are never queued. A sector marked protected in its request is skipped without any bus activity. A program request first reads the target word and refuses to program if any bit would need to go from 0 to 1.

State machine: `ST_IDLE` (accepting) goes to `ST_FIN` for a protected erase, to `ST_BLANK` for a program, and to `ST_CMD` otherwise. `ST_BLANK` goes to `ST_FIN` when the word is not erased, and to `ST_CMD` otherwise. `ST_CMD` steps through the command writes, then goes to `ST_IDRD` (identify) or `ST_POLL`. `ST_IDRD` performs two reads, then goes to `ST_RESET`. `ST_POLL` goes to `ST_CLR` in block style. In unlock style it goes to `ST_RESET` or `ST_FIN` on completion, to `ST_RESET` on timeout, and to `ST_GAP` otherwise. `ST_CLR` goes to `ST_RESET` on completion or timeout, and to `ST_GAP` otherwise. `ST_GAP` waits out the poll interval, then returns to `ST_POLL`. `ST_RESET` goes to `ST_FIN`, and `ST_FIN` goes back to `ST_IDLE`.

Top module: `nor_cmd_seq`

## Requirements
- R1: With req_op=0 (identify), whatever req_block is, the sequencer writes 0x00AA to UNLK0, 0x0055 to UNLK1 and 0x0090 to UNLK0. It then reads req_addr+0 into id_mfr and req_addr+1 into id_dev, and finally writes 0x00F0 to FIRST_SEC.
- R2: With req_op=1 (erase) and req_block=0, it writes AA@UNLK0, 55@UNLK1, 80@UNLK0, AA@UNLK0, 55@UNLK1 and 30@req_addr. It then reads req_addr until bit 7 is 1, and finally writes 0x00F0 to FIRST_SEC.
- R3: With req_op=2 (program) and req_block=0, it writes AA@UNLK0, 55@UNLK1, A0@UNLK0 and then req_data@req_addr. It then reads req_addr until bit 7 equals req_data bit 7, and on success it finishes with no further write.
- R4: With req_op=1 and req_block=1, it writes 0x60, 0xD0, 0x20 and 0xD0 to req_addr. It then polls req_addr, writing 0x0050 there after every status read, until bit 7 is 1, and finally writes 0x00FF to req_addr.
- R5: With req_op=2 and req_block=1, it writes 0x40 and then req_data to req_addr. It then polls and clears as in R4, and finally writes 0x00FF to req_addr.
- R6: A program first reads req_addr. If (read & req_data) != req_data, the sequencer sets rsp_nerr and finishes without any write.
- R7: An erase with req_prot=1 sets rsp_skip and finishes without any bus cycle.
- R8: A timer starts at the last command write. It is loaded from erase_tmo for an erase and from prog_tmo for a program, and it counts clock cycles. If a status read still shows busy after the timer has reached zero, the sequencer sets rsp_tmo and issues the read-mode write of its dialect (0x00F0 to FIRST_SEC, or 0x00FF to req_addr).
- R9: req_ready is high only while idle. busy is high from the cycle after acceptance through the done pulse, and done lasts one cycle.
- R10: Every bus cycle holds fl_ce_n low and its strobe (fl_we_n or fl_oe_n, never both) low for exactly STRB_CYC cycles, with fl_addr and fl_dq_o stable for the whole time fl_ce_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_op | input | 2 | 0 identify, 1 erase, 2 program |
| req_block | input | 1 | 1 selects block-style commands |
| req_addr | input | AW | Sector base or target word address |
| req_data | input | 16 | Word to program |
| req_prot | input | 1 | Sector is protected (erase is skipped) |
| erase_tmo | input | TW | Erase poll limit in cycles |
| prog_tmo | input | TW | Program poll limit in cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_nerr | output | 1 | Program refused: word not erased |
| rsp_tmo | output | 1 | Poll timed out |
| rsp_skip | output | 1 | Protected erase skipped |
| id_mfr | output | 16 | Manufacturer code |
| id_dev | output | 16 | Device code |
| fl_addr | output | AW | Flash word address |
| fl_dq_o | output | 16 | Flash write data |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 16 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |

## Verification
The bench targets the completion rules. A unlock-style program whose data has bit 7 clear must end on a status read with bit 7 clear. A design that waited for bit 7 to be 1 would time out instead, and one that sent a read-mode write after the program would emit an extra write. Block-style runs with several busy polls expect exactly one 0x50 clear per status read, so a missing or doubled clear changes the write stream. The blank check is exercised with a word whose result differs in one bit and with one where some bits are already zero but compatible; a design with an inverted or OR-based test fails one of them. Separate erase and program timeouts are driven with the other limit set large, so a design that uses the wrong limit either never times out or times out early.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_IDENT = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BLANK,
        ST_CMD,
        ST_POLL,
        ST_CLR,
        ST_GAP,
        ST_IDRD,
        ST_RESET,
        ST_FIN
    } seq_st_e;

    localparam logic [15:0] K_UNL_A    = 16'h00AA;
    localparam logic [15:0] K_UNL_B    = 16'h0055;
    localparam logic [15:0] K_AUTOSEL  = 16'h0090;
    localparam logic [15:0] K_ERS_SET  = 16'h0080;
    localparam logic [15:0] K_PRG_SET  = 16'h00A0;
    localparam logic [15:0] K_SEC_ERS  = 16'h0030;
    localparam logic [15:0] K_RD_ARRAY = 16'h00F0;
    localparam logic [15:0] K_B_UNLOCK = 16'h0060;
    localparam logic [15:0] K_B_CONF   = 16'h00D0;
    localparam logic [15:0] K_B_ERASE  = 16'h0020;
    localparam logic [15:0] K_B_PROG   = 16'h0040;
    localparam logic [15:0] K_B_CLRST  = 16'h0050;
    localparam logic [15:0] K_B_RDARR  = 16'h00FF;

endpackage

// File: rtl/nor_bus_cycle.sv
`timescale 1ns/1ps
module nor_bus_cycle #(
    parameter int AW       = 12,
    parameter int DW       = 16,
    parameter int STRB_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_i,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int CW = $clog2(STRB_CYC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD} ph_e;

    ph_e           ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            rd_q    <= 1'b0;
            fl_addr <= '0;
            fl_dq_o <= '0;
            rdata   <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (go) begin
                    ph      <= PH_SETUP;
                    rd_q    <= rd;
                    fl_addr <= addr;
                    fl_dq_o <= wdata;
                end
                PH_SETUP: begin
                    ph  <= PH_STRB;
                    cnt <= CW'(STRB_CYC - 1);
                end
                PH_STRB: begin
                    if (cnt == '0) begin
                        ph <= PH_HOLD;
                        if (rd_q) rdata <= fl_dq_i;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: ph <= PH_IDLE;
            endcase
        end
    end

    assign ack      = (ph == PH_HOLD);
    assign fl_ce_n  = (ph == PH_IDLE);
    assign fl_we_n  = !((ph == PH_STRB) && !rd_q);
    assign fl_oe_n  = !((ph == PH_STRB) && rd_q);
    assign fl_dq_oe = (ph != PH_IDLE) && !rd_q;

    // strobe-width observer for the R10 check
    logic [CW:0] low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     low_cnt <= '0;
        else if (!fl_we_n || !fl_oe_n)  low_cnt <= low_cnt + 1'b1;
        else                            low_cnt <= '0;
    end

    p_strobe_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (low_cnt == (CW+1)'(STRB_CYC)));
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

endmodule

// File: rtl/nor_poll_timer.sv
`timescale 1ns/1ps
module nor_poll_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= limit;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          TW        = 20,
    parameter int          STRB_CYC  = 3,
    parameter int          POLL_GAP  = 4,
    parameter logic [AW-1:0] UNLK0     = AW'('h555),
    parameter logic [AW-1:0] UNLK1     = AW'('h2AA),
    parameter logic [AW-1:0] FIRST_SEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic          req_block,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    input  logic          req_prot,
    input  logic [TW-1:0] erase_tmo,
    input  logic [TW-1:0] prog_tmo,
    output logic          busy,
    output logic          done,
    output logic          rsp_nerr,
    output logic          rsp_tmo,
    output logic          rsp_skip,
    output logic [15:0]   id_mfr,
    output logic [15:0]   id_dev,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [15:0]   fl_dq_i,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int GW = $clog2(POLL_GAP + 1);

    seq_st_e       st, nxt;
    op_e           op_q, op_in;
    logic          blk_q, ok_q;
    logic [AW-1:0] addr_q;
    logic [15:0]   data_q;
    logic [2:0]    step;
    logic [GW-1:0] gap_cnt;

    logic          b_go, b_rd, b_ack;
    logic [AW-1:0] b_addr, c_addr;
    logic [15:0]   b_data, c_data, b_rdata;
    logic          c_last, poll_ok, blank_bad, tmr_load, tmr_exp;

    assign op_in = (req_op == 2'd1) ? OP_ERASE : (req_op == 2'd2) ? OP_PROG : OP_IDENT;

    nor_bus_cycle #(.AW(AW), .DW(16), .STRB_CYC(STRB_CYC)) u_bus (
        .clk(clk), .rst_n(rst_n), .go(b_go), .rd(b_rd), .addr(b_addr), .wdata(b_data),
        .ack(b_ack), .rdata(b_rdata), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
        .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    assign tmr_load = (st == ST_CMD) && b_ack && c_last;

    nor_poll_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .limit((op_q == OP_ERASE) ? erase_tmo : prog_tmo), .expired(tmr_exp));

    // command step decoder
    always_comb begin
        c_addr = addr_q;
        c_data = data_q;
        c_last = 1'b0;
        if (blk_q) begin
            if (op_q == OP_PROG) begin
                c_data = (step == 3'd0) ? K_B_PROG : data_q;
                c_last = (step == 3'd1);
            end else begin
                unique case (step)
                    3'd0:    c_data = K_B_UNLOCK;
                    3'd2:    c_data = K_B_ERASE;
                    default: c_data = K_B_CONF;
                endcase
                c_last = (step == 3'd3);
            end
        end else begin
            unique case (step)
                3'd0: begin c_addr = UNLK0; c_data = K_UNL_A; end
                3'd1: begin c_addr = UNLK1; c_data = K_UNL_B; end
                3'd2: begin
                    c_addr = UNLK0;
                    c_data = (op_q == OP_IDENT) ? K_AUTOSEL :
                             (op_q == OP_ERASE) ? K_ERS_SET : K_PRG_SET;
                    c_last = (op_q == OP_IDENT);
                end
                3'd3: begin
                    if (op_q == OP_ERASE) begin c_addr = UNLK0; c_data = K_UNL_A; end
                    else                  c_last = 1'b1;
                end
                3'd4: begin c_addr = UNLK1; c_data = K_UNL_B; end
                default: begin c_data = K_SEC_ERS; c_last = 1'b1; end
            endcase
        end
    end

    assign poll_ok   = (!blk_q && op_q == OP_PROG) ? (b_rdata[7] == data_q[7]) : b_rdata[7];
    assign blank_bad = (b_rdata & data_q) != data_q;

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (req_valid)
                          nxt = (op_in == OP_ERASE && req_prot) ? ST_FIN :
                                (op_in == OP_PROG) ? ST_BLANK : ST_CMD;
            ST_BLANK: if (b_ack) nxt = blank_bad ? ST_FIN : ST_CMD;
            ST_CMD:   if (b_ack && c_last) nxt = (op_q == OP_IDENT) ? ST_IDRD : ST_POLL;
            ST_IDRD:  if (b_ack && step == 3'd1) nxt = ST_RESET;
            ST_POLL:  if (b_ack)
                          nxt = blk_q   ? ST_CLR :
                                poll_ok ? ((op_q == OP_PROG) ? ST_FIN : ST_RESET) :
                                tmr_exp ? ST_RESET : ST_GAP;
            ST_CLR:   if (b_ack) nxt = (ok_q || tmr_exp) ? ST_RESET : ST_GAP;
            ST_GAP:   if (gap_cnt == '0) nxt = ST_POLL;
            ST_RESET: if (b_ack) nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // operation context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_IDENT; blk_q <= 1'b0; ok_q <= 1'b0;
            addr_q <= '0; data_q <= '0; step <= '0; gap_cnt <= '0;
            rsp_nerr <= 1'b0; rsp_tmo <= 1'b0; rsp_skip <= 1'b0;
            id_mfr <= '0; id_dev <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    op_q     <= op_in;
                    blk_q    <= req_block && (op_in != OP_IDENT);
                    addr_q   <= req_addr;
                    data_q   <= req_data;
                    step     <= '0;
                    ok_q     <= 1'b0;
                    rsp_nerr <= 1'b0;
                    rsp_tmo  <= 1'b0;
                    rsp_skip <= (op_in == OP_ERASE) && req_prot;
                end
                ST_BLANK: if (b_ack && blank_bad) rsp_nerr <= 1'b1;
                ST_CMD:   if (b_ack) step <= c_last ? 3'd0 : step + 3'd1;
                ST_IDRD:  if (b_ack) begin
                    if (step == 3'd0) id_mfr <= b_rdata;
                    else              id_dev <= b_rdata;
                    step <= step + 3'd1;
                end
                ST_POLL:  if (b_ack) begin
                    ok_q    <= poll_ok;
                    gap_cnt <= GW'(POLL_GAP - 1);
                    if (!blk_q && !poll_ok && tmr_exp) rsp_tmo <= 1'b1;
                end
                ST_CLR:   if (b_ack) begin
                    gap_cnt <= GW'(POLL_GAP - 1);
                    if (!ok_q && tmr_exp) rsp_tmo <= 1'b1;
                end
                ST_GAP:   if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
                default: ;
            endcase
        end
    end

    // outputs and bus requests
    always_comb begin
        req_ready = (st == ST_IDLE);
        busy      = (st != ST_IDLE);
        done      = (st == ST_FIN);
        b_go      = 1'b0;
        b_rd      = 1'b0;
        b_addr    = addr_q;
        b_data    = data_q;
        unique case (st)
            ST_BLANK, ST_POLL: begin b_go = 1'b1; b_rd = 1'b1; end
            ST_IDRD:  begin b_go = 1'b1; b_rd = 1'b1; b_addr = addr_q + AW'(step); end
            ST_CMD:   begin b_go = 1'b1; b_addr = c_addr; b_data = c_data; end
            ST_CLR:   begin b_go = 1'b1; b_data = K_B_CLRST; end
            ST_RESET: begin
                b_go   = 1'b1;
                b_addr = blk_q ? addr_q : FIRST_SEC;
                b_data = blk_q ? K_B_RDARR : K_RD_ARRAY;
            end
            default: ;
        endcase
    end

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));
    p_skip_nobus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_skip && busy) |-> fl_ce_n);
    p_nerr_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_nerr && busy) |-> fl_we_n);
    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(rsp_tmo && (rsp_nerr || rsp_skip)));

endmodule

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
    localparam int AW = 12;
    localparam int TW = 20;
    localparam int STRB = 3;
    localparam int GAP = 4;
    localparam logic [11:0] U0 = 12'h555;
    localparam logic [11:0] U1 = 12'h2AA;
    localparam logic [11:0] FS = 12'h000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0, req_block = 1'b0, req_prot = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [11:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [TW-1:0] erase_tmo = TW'(5000), prog_tmo = TW'(5000);
    logic        req_ready, busy, done, rsp_nerr, rsp_tmo, rsp_skip;
    logic [15:0] id_mfr, id_dev, fl_dq_o, fl_dq_i;
    logic [11:0] fl_addr;
    logic        fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    nor_cmd_seq #(.AW(AW), .TW(TW), .STRB_CYC(STRB), .POLL_GAP(GAP),
                  .UNLK0(U0), .UNLK1(U1), .FIRST_SEC(FS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_block(req_block), .req_addr(req_addr), .req_data(req_data),
        .req_prot(req_prot), .erase_tmo(erase_tmo), .prog_tmo(prog_tmo),
        .busy(busy), .done(done), .rsp_nerr(rsp_nerr), .rsp_tmo(rsp_tmo), .rsp_skip(rsp_skip),
        .id_mfr(id_mfr), .id_dev(id_dev), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
        .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n));

    typedef struct { logic [11:0] a; logic [15:0] d; bit arm; } wr_t;
    wr_t exp_q[$];

    int errs = 0, checks = 0;
    int mmode = 0;                // 0 array, 1 id, 2 status
    int busy_left = 0, t_busy = 0, rd_count = 0;
    logic [15:0] arr_val = 16'hFFFF, mfr_v = 16'h0001, dev_v = 16'h22A3;
    logic [15:0] sbusy = 16'h0000, sdone = 16'h0080;
    logic [11:0] id_base = '0;
    string cur_req = "R0";
    bit finished = 0;

    always_comb begin
        if (mmode == 1)      fl_dq_i = (fl_addr == id_base) ? mfr_v : dev_v;
        else if (mmode == 2) fl_dq_i = (busy_left > 0) ? sbusy : sdone;
        else                 fl_dq_i = arr_val;
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expw(logic [11:0] a, logic [15:0] d, bit arm);
        wr_t e;
        e.a = a; e.d = d; e.arm = arm;
        exp_q.push_back(e);
    endtask

    // monitor: pops expected writes, models the flash read side
    task automatic monitor();
        int wl = 0;
        bit rl = 0;
        wr_t e;
        forever begin
            @(negedge clk);
            if (!fl_we_n) wl++;
            else if (wl != 0) begin
                chk(wl == STRB, "R10", "write strobe width", wl, STRB);
                if (exp_q.size() == 0) begin
                    chk(0, cur_req, "unexpected write", {4'h0, fl_addr, fl_dq_o}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(fl_addr == e.a && fl_dq_o == e.d, cur_req, "write addr/data",
                        {4'h0, fl_addr, fl_dq_o}, {4'h0, e.a, e.d});
                    if (e.arm) begin mmode = 2; busy_left = t_busy; end
                    else if (fl_dq_o == 16'h0090 && mmode == 0) mmode = 1;
                    else if (fl_dq_o == 16'h00F0 || fl_dq_o == 16'h00FF) mmode = 0;
                end
                wl = 0;
            end
            if (!fl_oe_n) rl = 1;
            else if (rl) begin
                rl = 0;
                rd_count++;
                if (mmode == 2 && busy_left > 0) busy_left--;
            end
        end
    endtask

    task automatic run_op(string tag, logic [1:0] op, bit blk, logic [11:0] a, logic [15:0] d,
                          bit prot, bit e_nerr, bit e_tmo, bit e_skip);
        int n = 0;
        bit bad = 0;
        cur_req = tag;
        mmode = 0;
        id_base = a;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_block = blk; req_addr = a; req_data = d; req_prot = prot;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 20000) begin
            if (!busy || req_ready) bad = 1;
            @(negedge clk);
            n++;
        end
        chk(done, tag, "done pulse seen", done, 1);
        chk(!bad, "R9", "busy high / ready low during op", bad, 0);
        chk(rsp_nerr == e_nerr, tag, "rsp_nerr", rsp_nerr, e_nerr);
        chk(rsp_tmo == e_tmo, tag, "rsp_tmo", rsp_tmo, e_tmo);
        chk(rsp_skip == e_skip, tag, "rsp_skip", rsp_skip, e_skip);
        chk(exp_q.size() == 0, tag, "expected writes left", exp_q.size(), 0);
        @(negedge clk);
        chk(!done && !busy && req_ready, "R9", "idle after one-cycle done", {busy, done}, 0);
    endtask

    task automatic main_seq();
        int r0;
        repeat (3) @(negedge clk);
        chk(!busy && req_ready && !done && fl_ce_n && fl_we_n && fl_oe_n, "R9",
            "reset state", {busy, req_ready, done, fl_ce_n}, 4'b0101);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 identify, unlock sequence even with block flag set
        for (int b = 0; b < 2; b++) begin
            mfr_v = 16'h0001 + 16'(b); dev_v = 16'h22A3 - 16'(b);
            expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(U0, 16'h0090, 0); expw(FS, 16'h00F0, 0);
            run_op("R1", 2'd0, bit'(b), 12'h100, 16'h0, 0, 0, 0, 0);
            chk(id_mfr == mfr_v, "R1", "manufacturer code", id_mfr, mfr_v);
            chk(id_dev == dev_v, "R1", "device code", id_dev, dev_v);
        end

        // R2 unlock erase, three busy polls
        t_busy = 3; sbusy = 16'h0000; sdone = 16'h0080;
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(U0, 16'h0080, 0);
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(12'h400, 16'h0030, 1);
        expw(FS, 16'h00F0, 0);
        run_op("R2", 2'd1, 0, 12'h400, 16'h0, 0, 0, 0, 0);

        // R3 unlock program, data bit 7 clear: done when bit 7 reads 0
        arr_val = 16'hFFFF; t_busy = 2; sbusy = 16'h3CDA; sdone = 16'h3C5A;
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(U0, 16'h00A0, 0); expw(12'h123, 16'h3C5A, 1);
        run_op("R3", 2'd2, 0, 12'h123, 16'h3C5A, 0, 0, 0, 0);

        // R3 unlock program, data bit 7 set
        t_busy = 1; sbusy = 16'h1225; sdone = 16'h12A5;
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(U0, 16'h00A0, 0); expw(12'h124, 16'h12A5, 1);
        run_op("R3", 2'd2, 0, 12'h124, 16'h12A5, 0, 0, 0, 0);

        // R4 block erase, clear after each of three status reads
        t_busy = 2; sbusy = 16'h0000; sdone = 16'h0080;
        expw(12'h800, 16'h0060, 0); expw(12'h800, 16'h00D0, 0);
        expw(12'h800, 16'h0020, 0); expw(12'h800, 16'h00D0, 1);
        for (int i = 0; i < 3; i++) expw(12'h800, 16'h0050, 0);
        expw(12'h800, 16'h00FF, 0);
        run_op("R4", 2'd1, 1, 12'h800, 16'h0, 0, 0, 0, 0);

        // R5 block program
        arr_val = 16'hFFFF; t_busy = 1;
        expw(12'h234, 16'h0040, 0); expw(12'h234, 16'h5511, 1);
        for (int i = 0; i < 2; i++) expw(12'h234, 16'h0050, 0);
        expw(12'h234, 16'h00FF, 0);
        run_op("R5", 2'd2, 1, 12'h234, 16'h5511, 0, 0, 0, 0);

        // R6 not erased: refused in both dialects, no writes
        arr_val = 16'h0F0F;
        run_op("R6", 2'd2, 0, 12'h300, 16'h1234, 0, 1, 0, 0);
        run_op("R6", 2'd2, 1, 12'h300, 16'h1234, 0, 1, 0, 0);
        // R6 boundary: zero bits already present but compatible
        arr_val = 16'hFF0F; t_busy = 0; sbusy = 16'h1283; sdone = 16'h1203;
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(U0, 16'h00A0, 0); expw(12'h301, 16'h1203, 1);
        run_op("R6", 2'd2, 0, 12'h301, 16'h1203, 0, 0, 0, 0);

        // R7 protected erase: no bus cycle at all
        r0 = rd_count;
        run_op("R7", 2'd1, 0, 12'h500, 16'h0, 1, 0, 0, 1);
        chk(rd_count == r0, "R7", "no reads for skipped sector", rd_count - r0, 0);

        // R8 erase timeout (program limit large)
        erase_tmo = TW'(60); prog_tmo = TW'(5000);
        t_busy = 1000000; sbusy = 16'h0000; sdone = 16'h0080;
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(U0, 16'h0080, 0);
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(12'h600, 16'h0030, 1);
        expw(FS, 16'h00F0, 0);
        run_op("R8", 2'd1, 0, 12'h600, 16'h0, 0, 0, 1, 0);

        // R8 program timeout (erase limit large)
        erase_tmo = TW'(5000); prog_tmo = TW'(40);
        arr_val = 16'hFFFF; sbusy = 16'h0080; sdone = 16'h0000;
        expw(U0, 16'h00AA, 0); expw(U1, 16'h0055, 0); expw(U0, 16'h00A0, 0); expw(12'h700, 16'h0011, 1);
        expw(FS, 16'h00F0, 0);
        run_op("R8", 2'd2, 0, 12'h700, 16'h0011, 0, 0, 1, 0);
        prog_tmo = TW'(5000);
    endtask

    initial begin
        fork
            monitor();
            begin
                repeat (150000) @(posedge clk);
                if (!finished) begin
                    errs++; checks++;
                    $display("FAIL watchdog: actual=hung expected=finished");
                    $display("Result: errors=%0d of %0d checks", errs, checks);
                    $finish;
                end
            end
        join_none
        main_seq();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule